// File: doc/BRIEF.md
# Status LED Blink-Code Generator

This block drives a red and a green board status LED with repeating blink codes. Four synchronous status levels come in: the module's power-good level, the module's 3.3 V output-present level, an active-low USB over-current alert, and a flag that is high while the JTAG path to the module's programmable logic is selected. A fixed priority maps these levels to one code per LED. Each code is solid dark, solid lit, or a pulse count N from 1 to 8.

The system clock is divided into slots of `SLOT_CYCLES` cycles, and eight slots make one frame. A pulse code of N lights its LED during the first half of each of the first N slots of the frame. The rest of the frame is the pause that separates one repetition from the next. The block adopts a new code only when a frame ends, so a code that is being shown is never cut short. The block does not debounce its inputs, sense voltages or switch power rails.

Top module: `status_blink_top`

## Requirements
- R1: A frame is 8 slots of `SLOT_CYCLES` cycles. The first frame begins at the first rising edge after reset is released. After the n-th rising edge following reset (n ≥ 1), each output shows frame position p = n−1. A pulse code N (legal values 1 to 8) can light its LED only while slot(p) = (p mod 8·SLOT_CYCLES) / SLOT_CYCLES is less than N. The LED stays dark in the remaining 8−N slots.
- R2: Inside a lit slot, the LED is on while (p mod SLOT_CYCLES) < SLOT_CYCLES/2 and off for the rest of the slot.
- R3: When the power-good, 3.3 V-present and over-current inputs are all high, the red LED is solid dark. If, in addition, the JTAG-select input is low, the green LED is solid lit. The red LED is never solid lit.
- R4: When power-good is low or 3.3 V-present is low, the red LED shows pulse code `PWR_ERR_PULSES` (default 1).
- R5: When the over-current input is low and there is no R4 condition, the red LED shows pulse code `USB_ERR_PULSES` (default 5). An R4 condition takes priority.
- R6: When the JTAG-select input is high, the green LED shows pulse code `JTAG_PULSES` (default 5), whatever the error inputs are. When JTAG-select is low and any error condition is present, the green LED is solid dark.
- R7: Each LED changes its code only at a frame boundary. An input change in the middle of a frame leaves the rest of that frame on the old code, and the new code starts with the next frame.
- R8: A synchronous active-high reset clears the divider, the slot counter and both held codes. The outputs are low from the first edge in reset, and the first frame after reset is dark on both LEDs whatever the inputs are.
- R9: The inputs pass through a `SYNC_STAGES`-deep register chain (default 2). A level present at least three rising edges before the frame-closing edge selects the next frame's code. A level that arrives later takes effect one frame after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| som_pgood_i | input | 1 | Module power-good level, high when good |
| som_3v3_i | input | 1 | Module 3.3 V output present, high when present |
| usb_oc_n_i | input | 1 | USB over-current alert, low on fault |
| jtag_cpld_sel_i | input | 1 | High while the JTAG path to the module's programmable logic is selected |
| led_red_o | output | 1 | Red status LED drive, registered, high = lit |
| led_green_o | output | 1 | Green status LED drive, registered, high = lit |

## Verification
The bench builds the block with `SLOT_CYCLES` = 8, so a frame lasts 64 clock cycles and every half-slot of every frame is sampled at the outputs. The pulse-count parameters keep their defaults, so codes 1 and 5 and both solid levels are checked against a position model. Input changes are placed in the middle of frames and at two and three edges before a frame boundary, which checks frame holding and the synchronizer's latency as well as the priority mapping.

// File: rtl/blink_pkg.sv
package blink_pkg;

  localparam int unsigned FRAME_SLOTS = 8;
  localparam int unsigned SLOT_W      = $clog2(FRAME_SLOTS);
  localparam int unsigned PULSE_W     = $clog2(FRAME_SLOTS + 1);
  localparam int unsigned NUM_LEDS    = 2;
  localparam int unsigned LED_RED     = 0;
  localparam int unsigned LED_GREEN   = 1;

  typedef enum logic [1:0] {
    LED_DARK  = 2'd0,
    LED_SOLID = 2'd1,
    LED_PULSE = 2'd2
  } led_mode_e;

  typedef struct packed {
    led_mode_e            mode;
    logic [PULSE_W-1:0]   pulses;
  } led_code_t;

  localparam led_code_t CODE_DARK  = '{mode: LED_DARK,  pulses: '0};
  localparam led_code_t CODE_SOLID = '{mode: LED_SOLID, pulses: '0};

  function automatic led_code_t pulse_code(input int unsigned n);
    led_code_t c;
    c.mode   = LED_PULSE;
    c.pulses = PULSE_W'(n);
    return c;
  endfunction

endpackage

// File: rtl/blink_sync.sv
module blink_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/blink_timebase.sv
module blink_timebase
  import blink_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES = 6_250_000,
  localparam int unsigned DIV_W      = $clog2(SLOT_CYCLES)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DIV_W-1:0]  div_cnt_o,
  output logic [SLOT_W-1:0] slot_idx_o,
  output logic              first_half_o,
  output logic              frame_end_o
);

  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(SLOT_CYCLES - 1);
  localparam logic [DIV_W-1:0]  DIV_HALF  = DIV_W'(SLOT_CYCLES / 2);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_SLOTS - 1);

  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] slot_q;
  logic              div_wrap;

  assign div_wrap = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      slot_q <= '0;
    end else if (div_wrap) begin
      div_q  <= '0;
      slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  assign div_cnt_o    = div_q;
  assign slot_idx_o   = slot_q;
  assign first_half_o = (div_q < DIV_HALF);
  assign frame_end_o  = div_wrap && (slot_q == SLOT_LAST);

endmodule

// File: rtl/blink_code_sel.sv
module blink_code_sel
  import blink_pkg::*;
#(
  parameter int unsigned PWR_ERR_PULSES = 1,
  parameter int unsigned USB_ERR_PULSES = 5,
  parameter int unsigned JTAG_PULSES    = 5
) (
  input  logic      pgood_i,
  input  logic      rail_ok_i,
  input  logic      usb_oc_n_i,
  input  logic      jtag_sel_i,
  output led_code_t red_code_o,
  output led_code_t green_code_o
);

  localparam led_code_t PWR_CODE  = pulse_code(PWR_ERR_PULSES);
  localparam led_code_t USB_CODE  = pulse_code(USB_ERR_PULSES);
  localparam led_code_t JTAG_CODE = pulse_code(JTAG_PULSES);

  logic pwr_fail;
  logic usb_fail;

  assign pwr_fail = !pgood_i || !rail_ok_i;
  assign usb_fail = !usb_oc_n_i;

  always_comb begin
    if (pwr_fail)      red_code_o = PWR_CODE;
    else if (usb_fail) red_code_o = USB_CODE;
    else               red_code_o = CODE_DARK;
  end

  always_comb begin
    if (jtag_sel_i)                 green_code_o = JTAG_CODE;
    else if (!pwr_fail && !usb_fail) green_code_o = CODE_SOLID;
    else                            green_code_o = CODE_DARK;
  end

endmodule

// File: rtl/blink_led_drv.sv
module blink_led_drv
  import blink_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end_i,
  input  logic [SLOT_W-1:0] slot_idx_i,
  input  logic              first_half_i,
  input  led_code_t         code_i,
  output led_code_t         code_q_o,
  output logic              led_o
);

  led_code_t code_q;
  logic      lit;
  logic      led_q;

  always_comb begin
    case (code_q.mode)
      LED_SOLID: lit = 1'b1;
      LED_PULSE: lit = first_half_i && (PULSE_W'(slot_idx_i) < code_q.pulses);
      default:   lit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= CODE_DARK;
      led_q  <= 1'b0;
    end else begin
      if (frame_end_i) code_q <= code_i;
      led_q <= lit;
    end
  end

  assign code_q_o = code_q;
  assign led_o    = led_q;

endmodule

// File: rtl/status_blink_top.sv
module status_blink_top
  import blink_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES    = 6_250_000,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned PWR_ERR_PULSES = 1,
  parameter int unsigned USB_ERR_PULSES = 5,
  parameter int unsigned JTAG_PULSES    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic som_pgood_i,
  input  logic som_3v3_i,
  input  logic usb_oc_n_i,
  input  logic jtag_cpld_sel_i,
  output logic led_red_o,
  output logic led_green_o
);

  localparam int unsigned DIV_W  = $clog2(SLOT_CYCLES);
  localparam int unsigned NUM_IN = 4;

  logic [NUM_IN-1:0] raw_lv;
  logic [NUM_IN-1:0] sync_lv;
  logic              pg_s, v33_s, usb_s, jtag_s;

  logic [DIV_W-1:0]  div_cnt;
  logic [SLOT_W-1:0] slot_idx;
  logic              first_half;
  logic              frame_end;

  led_code_t         sel_code [NUM_LEDS];
  led_code_t         act_code [NUM_LEDS];
  logic [NUM_LEDS-1:0] led_bits;
  led_code_t         red_act, green_act;

  assign raw_lv = {jtag_cpld_sel_i, usb_oc_n_i, som_3v3_i, som_pgood_i};

  blink_sync #(
    .WIDTH  (NUM_IN),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_lv),
    .q_o (sync_lv)
  );

  assign pg_s   = sync_lv[0];
  assign v33_s  = sync_lv[1];
  assign usb_s  = sync_lv[2];
  assign jtag_s = sync_lv[3];

  blink_timebase #(
    .SLOT_CYCLES(SLOT_CYCLES)
  ) u_timebase (
    .clk          (clk),
    .rst          (rst),
    .div_cnt_o    (div_cnt),
    .slot_idx_o   (slot_idx),
    .first_half_o (first_half),
    .frame_end_o  (frame_end)
  );

  blink_code_sel #(
    .PWR_ERR_PULSES(PWR_ERR_PULSES),
    .USB_ERR_PULSES(USB_ERR_PULSES),
    .JTAG_PULSES   (JTAG_PULSES)
  ) u_code_sel (
    .pgood_i      (pg_s),
    .rail_ok_i    (v33_s),
    .usb_oc_n_i   (usb_s),
    .jtag_sel_i   (jtag_s),
    .red_code_o   (sel_code[LED_RED]),
    .green_code_o (sel_code[LED_GREEN])
  );

  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_led
    blink_led_drv u_drv (
      .clk          (clk),
      .rst          (rst),
      .frame_end_i  (frame_end),
      .slot_idx_i   (slot_idx),
      .first_half_i (first_half),
      .code_i       (sel_code[g]),
      .code_q_o     (act_code[g]),
      .led_o        (led_bits[g])
    );
  end

  assign red_act     = act_code[LED_RED];
  assign green_act   = act_code[LED_GREEN];
  assign led_red_o   = led_bits[LED_RED];
  assign led_green_o = led_bits[LED_GREEN];

endmodule

// File: rtl/status_blink_chk.sv
module status_blink_chk
  import blink_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES    = 6_250_000,
  parameter int unsigned PWR_ERR_PULSES = 1,
  parameter int unsigned USB_ERR_PULSES = 5,
  parameter int unsigned JTAG_PULSES    = 5,
  localparam int unsigned DIV_W         = $clog2(SLOT_CYCLES)
) (
  input logic              clk,
  input logic              rst,
  input logic              led_red_o,
  input logic              led_green_o,
  input logic              pg_s,
  input logic              v33_s,
  input logic              usb_s,
  input logic              jtag_s,
  input logic [DIV_W-1:0]  div_cnt,
  input logic              frame_end,
  input led_code_t         red_act,
  input led_code_t         green_act
);

  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOT_CYCLES - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(SLOT_CYCLES / 2);
  localparam led_code_t PWR_CODE  = pulse_code(PWR_ERR_PULSES);
  localparam led_code_t USB_CODE  = pulse_code(USB_ERR_PULSES);
  localparam led_code_t JTAG_CODE = pulse_code(JTAG_PULSES);

  // R8
  leds_dark_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!led_red_o && !led_green_o));

  // R1
  divider_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (div_cnt == DIV_LAST) |=> (div_cnt == '0));

  // R2
  red_half_slot_chk: assert property (@(posedge clk) disable iff (rst)
    led_red_o |-> ($past(div_cnt) < DIV_HALF));

  // R2
  green_pulse_half_chk: assert property (@(posedge clk) disable iff (rst)
    (led_green_o && $past(green_act.mode) == LED_PULSE) |-> ($past(div_cnt) < DIV_HALF));

  // R7
  red_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(red_act));

  // R7
  green_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(green_act));

  // R4
  pwr_err_code_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end && (!pg_s || !v33_s)) |=> (red_act == PWR_CODE));

  // R5
  usb_err_code_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end && pg_s && v33_s && !usb_s) |=> (red_act == USB_CODE));

  // R6
  jtag_code_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end && jtag_s) |=> (green_act == JTAG_CODE));

  // R3
  red_never_solid_chk: assert property (@(posedge clk) disable iff (rst)
    red_act.mode != LED_SOLID);

endmodule

bind status_blink_top status_blink_chk #(
  .SLOT_CYCLES   (SLOT_CYCLES),
  .PWR_ERR_PULSES(PWR_ERR_PULSES),
  .USB_ERR_PULSES(USB_ERR_PULSES),
  .JTAG_PULSES   (JTAG_PULSES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .led_red_o   (led_red_o),
  .led_green_o (led_green_o),
  .pg_s        (pg_s),
  .v33_s       (v33_s),
  .usb_s       (usb_s),
  .jtag_s      (jtag_s),
  .div_cnt     (div_cnt),
  .frame_end   (frame_end),
  .red_act     (red_act),
  .green_act   (green_act)
);

// File: tb/status_blink_top_tb.sv
`timescale 1ns/1ps
module status_blink_top_tb;

  localparam int SLOT  = 8;
  localparam int FRAME = 8 * SLOT;
  localparam int M_DARK = 0, M_SOLID = 1, M_PULSE = 2;

  typedef struct {
    int    rm, rn, gm, gn;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg = 1'b1, v33 = 1'b1, usbn = 1'b1, jtag = 1'b0;
  logic led_r, led_g;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  int pushed = 0;
  bit have   = 1'b0;
  exp_t q[$];
  exp_t cur;
  exp_t last_e;

  always #4 clk = ~clk;

  status_blink_top #(.SLOT_CYCLES(SLOT)) u_dut (
    .clk             (clk),
    .rst             (rst),
    .som_pgood_i     (pg),
    .som_3v3_i       (v33),
    .usb_oc_n_i      (usbn),
    .jtag_cpld_sel_i (jtag),
    .led_red_o       (led_r),
    .led_green_o     (led_g)
  );

  always @(posedge clk) edges <= rst ? 0 : edges + 1;

  function automatic logic model_lit(int m, int n, int p);
    int slot = (p % FRAME) / SLOT;
    int d    = p % SLOT;
    if (m == M_SOLID) return 1'b1;
    if (m == M_PULSE) return (slot < n) && (d < SLOT / 2);
    return 1'b0;
  endfunction

  task automatic check_bit(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  // monitor: pops one expected frame at each frame start, compares mid-half samples
  always @(negedge clk) begin
    if (!rst && edges > 0) begin
      int p = edges - 1;
      if (p % FRAME == 0) begin
        if (q.size() > 0) begin cur = q.pop_front(); have = 1'b1; end
        else have = 1'b0;
      end
      if (have && (p % 4 == 2)) begin
        check_bit($sformatf("red %s (R1/R2 pattern, R7 hold) pos=%0d", cur.tag, p),
                  led_r, model_lit(cur.rm, cur.rn, p));
        check_bit($sformatf("green %s (R1/R2 pattern, R7 hold) pos=%0d", cur.tag, p),
                  led_g, model_lit(cur.gm, cur.gn, p));
      end
    end
  end

  task automatic push_exp(exp_t e);
    q.push_back(e);
    last_e = e;
    pushed++;
  endtask

  // driver: changes inputs at offset off of the frame before frame "pushed"
  task automatic apply(int off, logic a_pg, logic a_v33, logic a_usbn, logic a_jtag,
                       int rm, int rn, int gm, int gn, string tag, bit late);
    exp_t e;
    forever begin
      @(negedge clk);
      if (edges > 0 && ((edges - 1) / FRAME == pushed - 1) && ((edges - 1) % FRAME == off))
        break;
    end
    pg = a_pg; v33 = a_v33; usbn = a_usbn; jtag = a_jtag;
    if (late) begin
      e = last_e;
      e.tag = {tag, " old code kept (R9)"};
      push_exp(e);
    end
    e.rm = rm; e.rn = rn; e.gm = gm; e.gn = gn; e.tag = tag;
    push_exp(e);
  endtask

  initial begin
    exp_t e0;
    e0.rm = M_DARK; e0.rn = 0; e0.gm = M_DARK; e0.gn = 0;
    e0.tag = "R8 first frame dark";
    push_exp(e0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit("R8 red low in reset", led_r, 1'b0);
    check_bit("R8 green low in reset", led_g, 1'b0);
    rst = 1'b0;

    apply(32, 1, 1, 1, 0, M_DARK, 0, M_SOLID, 0, "R3 all good", 0);
    apply(32, 0, 1, 1, 0, M_PULSE, 1, M_DARK, 0, "R4 pgood low", 0);
    apply(32, 1, 0, 1, 0, M_PULSE, 1, M_DARK, 0, "R4 3v3 low", 0);
    apply(32, 1, 1, 0, 0, M_PULSE, 5, M_DARK, 0, "R5 usb over-current", 0);
    apply(32, 0, 1, 0, 0, M_PULSE, 1, M_DARK, 0, "R5 priority power over usb", 0);
    apply(32, 1, 1, 1, 1, M_DARK, 0, M_PULSE, 5, "R6 jtag selected ok", 0);
    apply(32, 1, 1, 0, 1, M_PULSE, 5, M_PULSE, 5, "R6 jtag with usb error", 0);
    apply(32, 1, 1, 1, 0, M_DARK, 0, M_SOLID, 0, "R3 back to good", 0);
    apply(FRAME - 4, 0, 1, 1, 0, M_PULSE, 1, M_DARK, 0, "R9 change 3 edges early", 0);
    apply(FRAME - 3, 1, 1, 1, 0, M_DARK, 0, M_SOLID, 0, "R9 change 2 edges early", 1);

    forever begin
      @(negedge clk);
      if ((edges - 1) / FRAME == pushed && (edges - 1) % FRAME == 8) break;
    end
    check_bit("R3 green solid before reset", led_g, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check_bit("R8 red cleared by reset", led_r, 1'b0);
    check_bit("R8 green cleared by reset", led_g, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule